// File: doc/BRIEF.md
# Oscillator Stabilization Status Counter

This block runs on an external crystal oscillator clock. It counts oscillator cycles from the moment the oscillator is allowed to run. That moment is either the oscillator-halt control falling from 1 to 0, or the release of a low-power stop mode. The block reports the elapsed time as an 8-bit thermometer-coded status byte. Software can read the byte to decide when the crystal clock is safe to use.

Each status bit stands for one wait threshold. A threshold is a power of two plus a fixed 16-cycle offset, and the exponents are not evenly spaced. The bits fill from the most significant end, and a bit never falls back while counting continues. Three things clear the counter and the status to zero and hold them there: reset, entering stop mode, and a high halt control. The cycle counter saturates at the last threshold, so it never wraps.

Top module: `osc_stab_monitor`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: Status bit 7 down to bit 0 sets on the oscillator edge that completes exactly 2^E+OFFSET counted cycles. The default exponents E are 8, 9, 10, 11, 13, 15, 17 and 18, and the default OFFSET is 16. One edge before a threshold, the byte still shows the previous value.
- R3: The byte is always a thermometer code filled from bit 7. The successive values are 0x80, 0xC0, 0xE0, 0xF0, 0xF8, 0xFC, 0xFE and 0xFF.
- R4: Set bits are sticky. Once 0xFF is reached the byte holds 0xFF for as long as counting continues. The counter saturates at the last threshold and never wraps.
- R5: While the halt control is 1, the counter and the status are cleared on the next edge and held at zero.
- R6: When the halt control is 0 and no stop mode is active, counting starts. The first counted edge is the first edge that samples the halt control low.
- R7: A stop-entry pulse clears the counter and the status. Both stay at zero until stop release, even with the halt control low. When entry and release are pulsed on the same edge, entry wins.
- R8: A stop-release pulse resumes counting from zero. The edge that samples the release pulse is the first counted cycle.
- R9: The read data equals the status byte while the read enable is 1 and is 0x00 otherwise. Reading has no effect on counting or on the status.
- R10: A clear event in the middle of a count restarts the whole sequence from 0x00, with the full threshold timings measured from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_halt | input | 1 | Oscillator-halt control; 1 stops and clears, 1-to-0 starts counting |
| stop_enter | input | 1 | One-cycle pulse on entry to stop mode |
| stop_release | input | 1 | One-cycle pulse on release from stop mode |
| rd_en | input | 1 | Read enable of the status port |
| rd_data | output | N_STAGE | Status byte when rd_en is 1, zero otherwise |

## Verification
A status bit becomes visible just after the edge that completes its threshold count. The edge where the halt control is first sampled low, or where a release pulse is sampled, counts as cycle one. A clear takes effect on the first edge that samples it. The read data is combinational and is due in the same cycle. The bench drives every input 2 ns after a rising edge and samples 1 ns later. It checks each bit one edge before its threshold and again on the threshold edge itself. Two instances are used: the main one has scaled-down exponents so the full sequence fits within the run time, and a second one uses the default exponents for the first five thresholds.

// File: rtl/ost_pkg.sv
`timescale 1ns/1ps
package ost_pkg;

    // Stop-mode tracking state held by the control unit.
    typedef struct packed {
        logic in_stop;
    } ost_ctrl_t;

    // Derived operating mode, used for readability of the control logic.
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_HALT  = 2'd1,
        MODE_SLEEP = 2'd2
    } ost_mode_e;

endpackage

// File: rtl/ost_ctrl.sv
`timescale 1ns/1ps
module ost_ctrl
    import ost_pkg::*;
(
    input  logic clk_osc,
    input  logic rst_n,
    input  logic osc_halt,
    input  logic stop_enter,
    input  logic stop_release,
    output logic cnt_clr,
    output logic cnt_adv
);

    ost_ctrl_t st_d, st_q;
    ost_mode_e mode;

    always_comb begin
        st_d = st_q;
        if (stop_enter) begin
            st_d.in_stop = 1'b1;
        end else if (stop_release) begin
            st_d.in_stop = 1'b0;
        end

        if (osc_halt) begin
            mode = MODE_HALT;
        end else if (stop_enter || (st_q.in_stop && !stop_release)) begin
            mode = MODE_SLEEP;
        end else begin
            mode = MODE_RUN;
        end

        cnt_clr = osc_halt || stop_enter;
        cnt_adv = (mode == MODE_RUN);
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Inside stop mode with no release pending, nothing advances.
    p_frozen_in_stop_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (st_q.in_stop && !stop_release) |-> !cnt_adv);

    // Entry beats release on the same edge.
    p_enter_wins_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (stop_enter && stop_release) |=> (st_q.in_stop && !$past(cnt_adv)));

    // A release with the oscillator running counts on that very edge.
    p_release_counts_r8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (stop_release && !stop_enter && !osc_halt) |-> cnt_adv);

    // Halt never lets the counter advance.
    p_halt_blocks_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        osc_halt |-> (cnt_clr && !cnt_adv));

endmodule

// File: rtl/ost_counter.sv
`timescale 1ns/1ps
module ost_counter #(
    parameter int unsigned CNT_W   = 19,
    parameter int unsigned SAT_VAL = 262160
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             cnt_adv,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_clr) begin
            cnt_d = '0;
        end else if (cnt_adv && (cnt_q != SAT)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
        cnt_nxt = cnt_d;
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cnt_q <= SAT);

    p_clear_zero_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cnt_clr |=> (cnt_q == '0));

    p_hold_idle_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (!cnt_clr && !cnt_adv) |=> $stable(cnt_q));

    p_single_step_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (cnt_adv && !cnt_clr && (cnt_q != SAT)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/ost_thermo.sv
`timescale 1ns/1ps
module ost_thermo #(
    parameter int unsigned              N_STAGE = 8,
    parameter int unsigned              CNT_W   = 19,
    parameter int unsigned              OFFSET  = 16,
    parameter logic [N_STAGE-1:0][4:0]  EXPS    = {5'd8, 5'd9, 5'd10, 5'd11,
                                                   5'd13, 5'd15, 5'd17, 5'd18}
) (
    input  logic               clk_osc,
    input  logic               rst_n,
    input  logic               cnt_clr,
    input  logic [CNT_W-1:0]   cnt_nxt,
    output logic [N_STAGE-1:0] status_q
);

    logic [N_STAGE-1:0] hit;
    logic [N_STAGE-1:0] status_d;
    logic [N_STAGE-1:0] gap;

    for (genvar gi = 0; gi < N_STAGE; gi++) begin : g_stage
        localparam logic [CNT_W-1:0] THR = CNT_W'((64'd1 << EXPS[gi]) + 64'(OFFSET));
        assign hit[gi] = (cnt_nxt == THR);
    end

    always_comb begin
        if (cnt_clr) begin
            status_d = '0;
        end else begin
            status_d = status_q | hit;
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign gap = ~status_q;

    // Ones only at the top, zeros only at the bottom.
    p_thermo_shape_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ((gap & N_STAGE'(gap + N_STAGE'(1))) == '0));

    p_sticky_bits_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !cnt_clr |=> ((status_q & $past(status_q)) == $past(status_q)));

    p_clear_status_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cnt_clr |=> (status_q == '0));

    p_at_most_one_new_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !cnt_clr |=> ($countones(status_q) <= $countones($past(status_q)) + 1));

endmodule

// File: rtl/osc_stab_monitor.sv
`timescale 1ns/1ps
module osc_stab_monitor #(
    parameter int unsigned              N_STAGE = 8,
    parameter int unsigned              CNT_W   = 19,
    parameter int unsigned              OFFSET  = 16,
    parameter logic [N_STAGE-1:0][4:0]  EXPS    = {5'd8, 5'd9, 5'd10, 5'd11,
                                                   5'd13, 5'd15, 5'd17, 5'd18}
) (
    input  logic               clk_osc,
    input  logic               rst_n,
    input  logic               osc_halt,
    input  logic               stop_enter,
    input  logic               stop_release,
    input  logic               rd_en,
    output logic [N_STAGE-1:0] rd_data
);

    // The lowest bit carries the longest wait, so the count stops there.
    localparam int unsigned SAT_VAL = int'((64'd1 << EXPS[0]) + 64'(OFFSET));

    logic               cnt_clr;
    logic               cnt_adv;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [CNT_W-1:0]   cnt_q;
    logic [N_STAGE-1:0] status_q;

    ost_ctrl u_ctrl (
        .clk_osc      (clk_osc),
        .rst_n        (rst_n),
        .osc_halt     (osc_halt),
        .stop_enter   (stop_enter),
        .stop_release (stop_release),
        .cnt_clr      (cnt_clr),
        .cnt_adv      (cnt_adv)
    );

    ost_counter #(
        .CNT_W   (CNT_W),
        .SAT_VAL (SAT_VAL)
    ) u_counter (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .cnt_clr (cnt_clr),
        .cnt_adv (cnt_adv),
        .cnt_nxt (cnt_nxt),
        .cnt_q   (cnt_q)
    );

    ost_thermo #(
        .N_STAGE (N_STAGE),
        .CNT_W   (CNT_W),
        .OFFSET  (OFFSET),
        .EXPS    (EXPS)
    ) u_thermo (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .cnt_nxt  (cnt_nxt),
        .status_q (status_q)
    );

    assign rd_data = rd_en ? status_q : '0;

    // Once the count is saturated, every status bit is set.
    p_full_at_sat_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (cnt_q == CNT_W'(SAT_VAL)) |-> (status_q == '1));

    // A non-empty status implies a count at least as long as the first threshold.
    p_status_needs_count_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (status_q != '0) |-> (cnt_q >= CNT_W'((64'd1 << EXPS[N_STAGE-1]) + 64'(OFFSET))));

endmodule

// File: tb/osc_stab_monitor_tb.sv
`timescale 1ns/1ps
module osc_stab_monitor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_halt = 1'b1;
    logic       stop_enter = 1'b0;
    logic       stop_release = 1'b0;
    logic       rd_en = 1'b1;
    logic [7:0] rd_data;
    logic [7:0] rd_data_full;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Scaled exponents 2,3,4,5,7,9,11,12 with offset 16.
    osc_stab_monitor #(
        .N_STAGE (8),
        .CNT_W   (13),
        .OFFSET  (16),
        .EXPS    ({5'd2, 5'd3, 5'd4, 5'd5, 5'd7, 5'd9, 5'd11, 5'd12})
    ) u_dut (
        .clk_osc      (clk),
        .rst_n        (rst_n),
        .osc_halt     (osc_halt),
        .stop_enter   (stop_enter),
        .stop_release (stop_release),
        .rd_en        (rd_en),
        .rd_data      (rd_data)
    );

    osc_stab_monitor u_dut_full (
        .clk_osc      (clk),
        .rst_n        (rst_n),
        .osc_halt     (osc_halt),
        .stop_enter   (stop_enter),
        .stop_release (stop_release),
        .rd_en        (rd_en),
        .rd_data      (rd_data_full)
    );

    localparam int unsigned THR_T [8] = '{20, 24, 32, 48, 144, 528, 2064, 4112};
    localparam logic [7:0]  PAT_T [8] = '{8'h80, 8'hC0, 8'hE0, 8'hF0,
                                          8'hF8, 8'hFC, 8'hFE, 8'hFF};
    localparam int unsigned THR_F [5] = '{272, 528, 1040, 2064, 8208};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] exp);
        rd_en = 1'b1;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        int elapsed;
        // R1: reset value
        step(3);
        chk("R1 reset", 8'h00);
        rst_n = 1'b1;
        step(30);
        chk("R5 halt holds zero", 8'h00);

        // R2/R3: table walk of every threshold
        osc_halt = 1'b0;
        elapsed = 0;
        for (int i = 0; i < 8; i++) begin
            step(int'(THR_T[i]) - 1 - elapsed);
            chk("R2 one edge early", (i == 0) ? 8'h00 : PAT_T[i-1]);
            step(1);
            chk("R3 on threshold", PAT_T[i]);
            elapsed = int'(THR_T[i]);
        end

        // R4: holds full and saturated
        step(500);
        chk("R4 holds 0xFF", 8'hFF);

        // R9: read port gating
        rd_en = 1'b0;
        #1;
        check("R9 disabled read", rd_data, 8'h00);
        step(1);
        chk("R9 re-enabled read", 8'hFF);

        // R5: halt clears on next edge
        osc_halt = 1'b1;
        step(1);
        chk("R5 halt clears", 8'h00);
        step(50);
        chk("R5 halt holds", 8'h00);

        // R6: halt release starts count
        osc_halt = 1'b0;
        step(19);
        chk("R6 before first", 8'h00);
        step(1);
        chk("R6 first threshold", 8'h80);
        step(10);
        chk("R6 second threshold", 8'hC0);

        // R7: stop entry clears and freezes
        stop_enter = 1'b1;
        step(1);
        stop_enter = 1'b0;
        chk("R7 stop clears", 8'h00);
        step(100);
        chk("R7 frozen in stop", 8'h00);

        // R8: release counts from its own edge; reads off meanwhile (R9)
        stop_release = 1'b1;
        step(1);
        stop_release = 1'b0;
        rd_en = 1'b0;
        step(18);
        chk("R8 before first", 8'h00);
        rd_en = 1'b0;
        step(1);
        chk("R8 first threshold", 8'h80);
        step(80);
        chk("R9 reads did not disturb", 8'hF0);

        // R10: mid-count restart
        osc_halt = 1'b1;
        step(1);
        osc_halt = 1'b0;
        chk("R10 restart cleared", 8'h00);
        step(19);
        chk("R10 before first", 8'h00);
        step(1);
        chk("R10 first threshold", 8'h80);
        step(27);
        chk("R10 before fourth", 8'hE0);
        step(1);
        chk("R10 fourth threshold", 8'hF0);

        // R7: entry wins over a simultaneous release
        stop_enter = 1'b1;
        stop_release = 1'b1;
        step(1);
        stop_enter = 1'b0;
        stop_release = 1'b0;
        step(30);
        chk("R7 entry priority", 8'h00);
        stop_release = 1'b1;
        step(1);
        stop_release = 1'b0;

        // R2: default exponents on the full-size instance
        osc_halt = 1'b1;
        step(2);
        osc_halt = 1'b0;
        elapsed = 0;
        for (int i = 0; i < 5; i++) begin
            step(int'(THR_F[i]) - 1 - elapsed);
            #1;
            check("R2 default early", rd_data_full, (i == 0) ? 8'h00 : PAT_T[i-1]);
            step(1);
            #1;
            check("R2 default threshold", rd_data_full, PAT_T[i]);
            elapsed = int'(THR_F[i]);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule